// File: doc/BRIEF.md
# Mode-banked processor register file

This block is the architectural register file of a small 32-bit RISC core. Software sees sixteen registers, numbered 0 to 15. Behind them sit 27 physical 32-bit words. The word that backs a given index depends on the current processor mode. Each cycle the file serves two source operands through combinational read ports and accepts one destination write at the rising clock edge.

Registers 0 to 7 are common to every mode. The fast interrupt mode swaps in its own copies of registers 8 to 14. The interrupt and supervisor modes each swap in only their own registers 13 (the stack pointer) and 14 (the link register). Index 15 is a combined word: the program counter sits in the low 24 bits and the processor status byte in the top 8 bits. The status byte changes only when a dedicated enable is raised. The active mode is held in a small register inside the file and is loaded through its own enable.

Top module: `regbank_top`

## Requirements
- R1: While reset is high at a rising edge, every physical register clears to zero and the mode register becomes supervisor (2'b11).
- R2: Mode codes are 2'b00 user, 2'b01 fast interrupt, 2'b10 interrupt and 2'b11 supervisor. When `mode_we` is high at a rising edge, `mode_in` is loaded, and the new mode governs reads and writes from the following cycle onward. Otherwise the mode holds.
- R3: Indices 0 to 7 address the same eight words in all four modes.
- R4: In fast interrupt mode, indices 8 to 14 address seven private words, apart from the user words.
- R5: In interrupt mode, indices 13 and 14 address two private words, and indices 8 to 12 address the user words.
- R6: In supervisor mode, indices 13 and 14 address two private words, and indices 8 to 12 address the user words.
- R7: The two read ports are independent and combinational: each returns the word selected by its own index in the same cycle.
- R8: A write lands at the rising edge. In the cycle of the write, a read of the same index still returns the old value.
- R9: A write to index 15 loads bits [23:0] (program counter). Bits [31:24] (status byte) are loaded only when `stat_we` is also high, and are kept otherwise.
- R10: Index 15 is one word shared by all modes, and `r15_word` always shows it.
- R11: A write to index 14 (link) goes to the active mode's bank and leaves the index-14 words of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Load enable for the mode register |
| mode_in | input | 2 | Mode code to load |
| cur_mode | output | 2 | Mode currently in effect |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write architectural index |
| wr_data | input | 32 | Write data |
| stat_we | input | 1 | With a write to index 15, also load the status byte |
| r15_word | output | 32 | Combined program counter and status word |

## Verification
Read data has no register in its path. Each read is therefore checked one nanosecond after its index is driven on the falling edge, in the same cycle. Writes and mode loads take effect at the next rising edge. Their effects are checked on the falling edge that follows that edge, so one register stage separates stimulus from check. For the same-cycle rule, the check samples before the rising edge, with the write still pending, and again after it. Mode changes are checked both ways: the old mode is still in effect before the edge, and the new one after.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DATA_W  = 32;
    localparam int STAT_W  = 8;
    localparam int PC_W    = DATA_W - STAT_W;
    localparam int NARCH   = 16;
    localparam int IDX_W   = $clog2(NARCH);
    localparam int NUSR    = NARCH - 1;        // user bank: indices 0..14
    localparam int NFIQ    = 7;                // indices 8..14
    localparam int NSMALL  = 2;                // indices 13..14
    localparam int FIQ_LO  = NUSR - NFIQ;      // 8
    localparam int SML_LO  = NUSR - NSMALL;    // 13
    localparam int BASE_FIQ = NUSR;
    localparam int BASE_IRQ = BASE_FIQ + NFIQ;
    localparam int BASE_SVC = BASE_IRQ + NSMALL;
    localparam int NGPR    = BASE_SVC + NSMALL; // 26 ordinary words
    localparam int PHYS_PC = NGPR;              // 26
    localparam int NPHYS   = NGPR + 1;          // 27
    localparam int PHYS_W  = $clog2(NPHYS);

    typedef enum logic [1:0] {
        MODE_USR = 2'b00,
        MODE_FIQ = 2'b01,
        MODE_IRQ = 2'b10,
        MODE_SVC = 2'b11
    } mode_t;

    typedef logic [IDX_W-1:0]  arch_idx_t;
    typedef logic [PHYS_W-1:0] phys_idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic      en;
        phys_idx_t phys;
        word_t     data;
        logic      stat;
    } wr_req_t;

    function automatic phys_idx_t map_phys(input arch_idx_t idx, input mode_t m);
        int i;
        i = int'(idx);
        if (i == NARCH - 1)
            return phys_idx_t'(PHYS_PC);
        case (m)
            MODE_FIQ: if (i >= FIQ_LO) return phys_idx_t'(BASE_FIQ + i - FIQ_LO);
            MODE_IRQ: if (i >= SML_LO) return phys_idx_t'(BASE_IRQ + i - SML_LO);
            MODE_SVC: if (i >= SML_LO) return phys_idx_t'(BASE_SVC + i - SML_LO);
            default: ;
        endcase
        return phys_idx_t'(i);
    endfunction

endpackage

// File: rtl/rb_bank_map.sv
module rb_bank_map
    import regbank_pkg::*;
(
    input  arch_idx_t idx,
    input  mode_t     mode,
    output phys_idx_t phys
);
    always_comb phys = map_phys(idx, mode);
endmodule

// File: rtl/rb_storage.sv
module rb_storage
    import regbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wr_req_t   wr,
    input  phys_idx_t rd0_phys,
    input  phys_idx_t rd1_phys,
    output word_t     rd0_data,
    output word_t     rd1_data,
    output word_t     r15_word
);
    word_t             gpr [NGPR];
    logic [PC_W-1:0]   pc_q;
    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NGPR; p++) gpr[p] <= '0;
            pc_q   <= '0;
            stat_q <= '0;
        end else if (wr.en) begin
            if (wr.phys == phys_idx_t'(PHYS_PC)) begin
                pc_q <= wr.data[PC_W-1:0];
                if (wr.stat) stat_q <= wr.data[DATA_W-1:PC_W];
            end else begin
                for (int p = 0; p < NGPR; p++)
                    if (wr.phys == phys_idx_t'(p)) gpr[p] <= wr.data;
            end
        end
    end

    assign r15_word = {stat_q, pc_q};

    function automatic word_t pick(input phys_idx_t ph);
        word_t v;
        v = r15_word;
        for (int p = 0; p < NGPR; p++)
            if (ph == phys_idx_t'(p)) v = gpr[p];
        return v;
    endfunction

    always_comb begin
        rd0_data = pick(rd0_phys);
        rd1_data = pick(rd1_phys);
    end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_we,
    input  logic [1:0]  mode_in,
    output logic [1:0]  cur_mode,
    input  logic [3:0]  rd_a_idx,
    output logic [31:0] rd_a_data,
    input  logic [3:0]  rd_b_idx,
    output logic [31:0] rd_b_data,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        stat_we,
    output logic [31:0] r15_word
);
    localparam int NPORT = 3; // read A, read B, write

    mode_t     mode_q;
    arch_idx_t port_idx  [NPORT];
    phys_idx_t port_phys [NPORT];
    wr_req_t   wr;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= MODE_SVC;
        else if (mode_we) mode_q <= mode_t'(mode_in);
    end
    assign cur_mode = mode_q;

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    for (genvar k = 0; k < NPORT; k++) begin : g_map
        rb_bank_map u_map (
            .idx  (port_idx[k]),
            .mode (mode_q),
            .phys (port_phys[k])
        );
    end

    always_comb begin
        wr.en   = wr_en;
        wr.phys = port_phys[2];
        wr.data = wr_data;
        wr.stat = stat_we;
    end

    rb_storage u_store (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd0_phys (port_phys[0]),
        .rd1_phys (port_phys[1]),
        .rd0_data (rd_a_data),
        .rd1_data (rd_b_data),
        .r15_word (r15_word)
    );
endmodule

// File: rtl/rb_checker.sv
module rb_checker (
    input logic        clk,
    input logic        rst,
    input logic        mode_we,
    input logic [1:0]  mode_in,
    input logic [1:0]  cur_mode,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        stat_we,
    input logic [31:0] r15_word
);
    assert_mode_load_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(mode_we) |-> cur_mode == $past(mode_in));

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(mode_we) |-> $stable(cur_mode));

    assert_low_shared_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(mode_we) && !$past(wr_en) && rd_a_idx < 4'd8
        && rd_a_idx == $past(rd_a_idx) |-> rd_a_data == $past(rd_a_data));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_en) && !$past(mode_we) && $past(wr_idx) != 4'd15
        && rd_a_idx == $past(wr_idx) |-> rd_a_data == $past(wr_data));

    assert_pc_load_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_en) && $past(wr_idx) == 4'd15
        |-> r15_word[23:0] == $past(wr_data[23:0]));

    assert_stat_keep_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !($past(wr_en) && $past(wr_idx) == 4'd15 && $past(stat_we))
        |-> $stable(r15_word[31:24]));

    assert_r15_view_R10: assert property (@(posedge clk) disable iff (rst)
        rd_a_idx == 4'd15 |-> rd_a_data == r15_word);
endmodule

bind regbank_top rb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_we   (mode_we),
    .mode_in   (mode_in),
    .cur_mode  (cur_mode),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .stat_we   (stat_we),
    .r15_word  (r15_word)
);

// File: tb/regbank_top_bench.sv
`timescale 1ns/1ps
module regbank_top_bench;
    localparam logic [1:0] USR = 2'b00, FIQ = 2'b01, IRQ = 2'b10, SVC = 2'b11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0;
    logic [1:0]  mode_in = 2'b00;
    logic [1:0]  cur_mode;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, r15_word;
    logic        wr_en = 1'b0, stat_we = 1'b0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    regbank_top u_regbank_top (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_in(mode_in),
        .cur_mode(cur_mode), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .stat_we(stat_we),
        .r15_word(r15_word)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic set_mode(input logic [1:0] m);
        mode_we = 1'b1; mode_in = m;
        @(posedge clk); @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d, input logic s = 1'b0);
        wr_en = 1'b1; wr_idx = i; wr_data = d; stat_we = s;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; stat_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [3:0] i, input logic [31:0] exp);
        rd_a_idx = i; #1;
        chk(tag, rd_a_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 mode after reset", {30'd0, cur_mode}, {30'd0, SVC});
        for (int i = 0; i < 16; i++) rd("R1 reg zero after reset", 4'(i), 32'd0);
        chk("R1 r15 zero", r15_word, 32'd0);
    endtask

    task automatic t_mode_timing();
        mode_we = 1'b1; mode_in = USR; #1;
        chk("R2 mode before edge", {30'd0, cur_mode}, {30'd0, SVC});
        @(posedge clk); @(negedge clk);
        mode_we = 1'b0;
        chk("R2 mode after edge", {30'd0, cur_mode}, {30'd0, USR});
        @(posedge clk); @(negedge clk);
        chk("R2 mode held", {30'd0, cur_mode}, {30'd0, USR});
    endtask

    task automatic t_shared();
        for (int i = 0; i < 8; i++) wr(4'(i), 32'h100 + i);
        for (int i = 8; i < 15; i++) wr(4'(i), 32'hA0 + i);
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            rd("R3 shared r0", 4'd0, 32'h100);
            rd("R3 shared r7", 4'd7, 32'h107);
        end
        set_mode(USR);
    endtask

    task automatic t_fiq();
        set_mode(FIQ);
        for (int i = 8; i < 15; i++) rd("R4 fiq private empty", 4'(i), 32'd0);
        wr(4'd8, 32'hF8); wr(4'd14, 32'hFE);
        set_mode(USR);
        rd("R4 user r8 kept", 4'd8, 32'hA8);
        rd("R4 user r14 kept", 4'd14, 32'hAE);
        set_mode(FIQ);
        rd("R4 fiq r8", 4'd8, 32'hF8);
        rd("R4 fiq r14", 4'd14, 32'hFE);
    endtask

    task automatic t_irq();
        set_mode(IRQ);
        for (int i = 8; i < 13; i++) rd("R5 irq sees user r8-12", 4'(i), 32'hA0 + i);
        rd("R5 irq r13 private", 4'd13, 32'd0);
        wr(4'd13, 32'h1D);
        rd("R5 irq r13 written", 4'd13, 32'h1D);
        set_mode(USR);
        rd("R5 user r13 kept", 4'd13, 32'hAD);
    endtask

    task automatic t_svc();
        set_mode(SVC);
        rd("R6 svc sees user r12", 4'd12, 32'hAC);
        rd("R6 svc r13 private", 4'd13, 32'd0);
        wr(4'd13, 32'h5D);
        rd("R6 svc r13 written", 4'd13, 32'h5D);
        set_mode(IRQ);
        rd("R6 irq r13 untouched", 4'd13, 32'h1D);
    endtask

    task automatic t_link();
        wr(4'd14, 32'hCAFE);          // still in interrupt mode
        rd("R11 irq link", 4'd14, 32'hCAFE);
        set_mode(SVC);  rd("R11 svc link untouched", 4'd14, 32'd0);
        set_mode(FIQ);  rd("R11 fiq link untouched", 4'd14, 32'hFE);
        set_mode(USR);  rd("R11 user link untouched", 4'd14, 32'hAE);
    endtask

    task automatic t_ports();
        rd_a_idx = 4'd2; rd_b_idx = 4'd9; #1;
        chk("R7 port A", rd_a_data, 32'h102);
        chk("R7 port B", rd_b_data, 32'hA9);
        rd_a_idx = 4'd11; rd_b_idx = 4'd4; #1;
        chk("R7 port A swap", rd_a_data, 32'hAB);
        chk("R7 port B swap", rd_b_data, 32'h104);
    endtask

    task automatic t_same_cycle();
        rd_a_idx = 4'd5; rd_b_idx = 4'd5;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h55; #1;
        chk("R8 old value before edge", rd_a_data, 32'h105);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; #1;
        chk("R8 new value after edge", rd_b_data, 32'h55);
    endtask

    task automatic t_r15();
        wr(4'd15, 32'hAB123456);
        chk("R9 pc only", r15_word, 32'h00123456);
        wr(4'd15, 32'hCD654321, 1'b1);
        chk("R9 pc and status", r15_word, 32'hCD654321);
        wr(4'd15, 32'h11000001);
        chk("R9 status kept", r15_word, 32'hCD000001);
        set_mode(FIQ);
        rd("R10 r15 in fiq", 4'd15, 32'hCD000001);
        set_mode(SVC);
        rd("R10 r15 in svc", 4'd15, 32'hCD000001);
        rd_b_idx = 4'd15; #1;
        chk("R10 r15 port B", rd_b_data, r15_word);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode_timing();
        t_shared();
        t_fiq();
        t_irq();
        t_svc();
        t_link();
        t_ports();
        t_same_cycle();
        t_r15();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule